// File: doc/BRIEF.md
# Low-Power Ordered Set Monitor

This block observes one direction of a serial link after symbol decoding. Each clock it receives one 8-bit symbol, a flag that marks the symbol as a control (K) character, and a separate line that is high while the link is electrically idle. It finds the two ordered sets that frame a low-power episode. The idle-entry set is COM IDL IDL IDL, coded 0xBC, 0x7C, 0x7C, 0x7C, all K. The fast-training set is COM FTS FTS FTS, coded 0xBC, 0x3C, 0x3C, 0x3C, all K. The block then follows the episode from entry through the silent period to the training burst that ends it.

A phase machine tracks the episode in three states:
- RUN: normal traffic.
- IDLE: the line is electrically idle.
- TRAIN: the training burst after idle.

The transitions are:
- RUN to IDLE, on idle rising.
- IDLE to TRAIN, on idle falling.
- TRAIN to RUN, on the first symbol that is not part of a training set.
- TRAIN to IDLE, if idle rises again during training.

The set matcher has six states:
- HUNT: waiting for a COM.
- COM: a COM has just been seen.
- EI1 and EI2: one and two IDL symbols seen after the COM.
- FT1 and FT2: one and two FTS symbols seen after the COM.

A COM from any state restarts the matcher in COM. Any other unexpected symbol, or an idle cycle, returns it to HUNT.

When idle ends, the block reports how long the line was idle and whether an idle-entry set came just before. When training ends, it reports how many full training sets arrived. A trigger fires when idle is entered, but only on the link side chosen for triggering. A drop flag, delayed four cycles, tells a capture path which symbols to discard. Two classes can be dropped, each with its own enable: idle-entry sets together with the idle cycles, and training sets.

Top module: `lowpower_os_monitor`

## Requirements
- R1: Four consecutive non-idle K symbols 0xBC,0x7C,0x7C,0x7C raise `eios_det` for exactly the one cycle after the fourth symbol.
- R2: Four consecutive non-idle K symbols 0xBC,0x3C,0x3C,0x3C raise `fts_det` for exactly the one cycle after the fourth symbol.
- R3: A set that breaks off early produces no detection. Breaks include a wrong symbol, a non-K symbol and an idle cycle. A COM arriving mid-set starts a new set.
- R4: `trig_pulse` is high for one cycle, the cycle after the first idle-high cycle of a period, when `trig_en`=1 and `trig_side`==`link_side`. Otherwise it stays low.
- R5: `idle_len_valid` pulses for one cycle, the cycle after the first idle-low cycle. `idle_len` then equals the number of cycles the idle line was high.
- R6: The idle length saturates at all ones (65535 by default) instead of wrapping.
- R7: `idle_after_eios` is reported with the idle length. It is 1 when the last non-idle cycle before the idle period completed an idle-entry set.
- R8: After idle, complete training sets are counted until the first non-idle symbol that is not part of a training set, or until idle returns. `fts_cnt_valid` pulses in the following cycle, with `fts_cnt` holding the count.
- R9: `drop_sym` in cycle t refers to the input of cycle t-4. It is 1 in two cases. First, for all four symbols of a recognised idle-entry set and for idle cycles, when `drop_idle_en` was 1 at the time. Second, for all four symbols of a recognised training set, when `drop_fts_en` was 1.
- R10: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one symbol per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_data | input | 8 | Decoded symbol |
| sym_is_k | input | 1 | Symbol is a control character |
| elec_idle | input | 1 | Line is electrically idle; symbol ignored |
| link_side | input | 1 | Side this stream comes from (0 down, 1 up) |
| trig_en | input | 1 | Enable idle-entry trigger |
| trig_side | input | 1 | Side allowed to trigger |
| drop_idle_en | input | 1 | Drop idle-entry sets and idle cycles |
| drop_fts_en | input | 1 | Drop training sets |
| eios_det | output | 1 | Idle-entry set seen (pulse) |
| fts_det | output | 1 | Training set seen (pulse) |
| trig_pulse | output | 1 | Idle-entry trigger (pulse) |
| idle_len_valid | output | 1 | Idle length report (pulse) |
| idle_len | output | IDLE_W | Idle length in cycles |
| idle_after_eios | output | 1 | Idle was preceded by an idle-entry set |
| fts_cnt_valid | output | 1 | Training count report (pulse) |
| fts_cnt | output | FTS_W | Number of training sets |
| drop_sym | output | 1 | Drop flag for the input of four cycles earlier |

## Verification
Two functions can fall in the same cycle. If idle returns while a training burst is still being counted, the training count report and the idle-entry trigger come out together. The bench provokes this directly: it ends a burst of training sets with a rising idle line. Random episodes repeat the same pattern many times. In each of those cycles, the bench model predicts both pulses and their values, and every output is compared each cycle against that model.

// File: rtl/lpos_pkg.sv
package lpos_pkg;
    localparam int OS_LEN = 4;
    localparam logic [7:0] SYM_COM = 8'hBC;
    localparam logic [7:0] SYM_IDL = 8'h7C;
    localparam logic [7:0] SYM_FTS = 8'h3C;

    typedef enum logic [2:0] {
        M_HUNT, M_COM, M_EI1, M_EI2, M_FT1, M_FT2
    } match_st_t;

    typedef enum logic [1:0] {
        PH_RUN, PH_IDLE, PH_TRAIN
    } phase_t;
endpackage

// File: rtl/lpos_os_matcher.sv
module lpos_os_matcher
    import lpos_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sym_data,
    input  logic       sym_is_k,
    input  logic       sym_gap,
    output logic       eios_hit,
    output logic       fts_hit,
    output logic       fts_part
);
    match_st_t st, nxt;
    logic is_com, is_idl, is_fts;

    assign is_com = sym_is_k && (sym_data == SYM_COM);
    assign is_idl = sym_is_k && (sym_data == SYM_IDL);
    assign is_fts = sym_is_k && (sym_data == SYM_FTS);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= M_HUNT;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = M_HUNT;
        eios_hit = 1'b0;
        fts_hit  = 1'b0;
        fts_part = 1'b0;
        if (!sym_gap) begin
            unique case (st)
                M_HUNT: ;
                M_COM: begin
                    if (is_idl) nxt = M_EI1;
                    else if (is_fts) begin
                        nxt = M_FT1;
                        fts_part = 1'b1;
                    end
                end
                M_EI1: if (is_idl) nxt = M_EI2;
                M_EI2: if (is_idl) eios_hit = 1'b1;
                M_FT1: begin
                    if (is_fts) begin
                        nxt = M_FT2;
                        fts_part = 1'b1;
                    end
                end
                M_FT2: begin
                    if (is_fts) begin
                        fts_hit  = 1'b1;
                        fts_part = 1'b1;
                    end
                end
                default: ;
            endcase
            if (is_com) begin
                nxt      = M_COM;
                fts_part = 1'b1;
            end
        end
    end

    AST_EIOS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        eios_hit |-> $past(is_com, 3)); // R1
    AST_FTS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        fts_hit |-> ($past(is_com, 3) && $past(is_fts, 1))); // R2
endmodule

// File: rtl/lpos_sat_cnt.sv
module lpos_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= '0;
        else if (clr)               q <= inc ? ONE : '0;
        else if (inc && (q != TOP)) q <= q + ONE;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((q == TOP) && !clr) |=> (q == TOP)); // R6
endmodule

// File: rtl/lpos_drop_filter.sv
module lpos_drop_filter
    import lpos_pkg::*;
#(
    parameter int LAT = OS_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eios_hit,
    input  logic fts_hit,
    input  logic gap,
    input  logic en_idle,
    input  logic en_fts,
    output logic drop
);
    logic [LAT-1:0] span_q;
    logic [LAT-1:0] gap_q;
    logic           mark;

    assign mark = (eios_hit && en_idle) || (fts_hit && en_fts);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
            gap_q  <= '0;
        end else begin
            span_q <= {span_q[LAT-2:0], 1'b0} | (mark ? {LAT{1'b1}} : '0);
            gap_q  <= {gap_q[LAT-2:0], gap && en_idle};
        end
    end

    assign drop = span_q[LAT-1] | gap_q[LAT-1];

    AST_DROP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gap && en_idle) |-> ##LAT drop); // R9
endmodule

// File: rtl/lowpower_os_monitor.sv
module lowpower_os_monitor
    import lpos_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int FTS_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sym_data,
    input  logic              sym_is_k,
    input  logic              elec_idle,
    input  logic              link_side,
    input  logic              trig_en,
    input  logic              trig_side,
    input  logic              drop_idle_en,
    input  logic              drop_fts_en,
    output logic              eios_det,
    output logic              fts_det,
    output logic              trig_pulse,
    output logic              idle_len_valid,
    output logic [IDLE_W-1:0] idle_len,
    output logic              idle_after_eios,
    output logic              fts_cnt_valid,
    output logic [FTS_W-1:0]  fts_cnt,
    output logic              drop_sym
);
    phase_t ph, ph_nxt;
    logic eios_hit, fts_hit, fts_part;
    logic ei_entry, idle_end, train_end;
    logic eios_flag;
    logic [IDLE_W-1:0] idle_q;
    logic [FTS_W-1:0]  fts_q;

    lpos_os_matcher u_match (
        .clk(clk), .rst_n(rst_n), .sym_data(sym_data), .sym_is_k(sym_is_k),
        .sym_gap(elec_idle), .eios_hit(eios_hit), .fts_hit(fts_hit),
        .fts_part(fts_part)
    );

    lpos_sat_cnt #(.W(IDLE_W)) u_idle_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ei_entry), .inc(elec_idle), .q(idle_q)
    );

    lpos_sat_cnt #(.W(FTS_W)) u_fts_cnt (
        .clk(clk), .rst_n(rst_n), .clr(idle_end),
        .inc(fts_hit && (ph == PH_TRAIN)), .q(fts_q)
    );

    lpos_drop_filter #(.LAT(OS_LEN)) u_filter (
        .clk(clk), .rst_n(rst_n), .eios_hit(eios_hit), .fts_hit(fts_hit),
        .gap(elec_idle), .en_idle(drop_idle_en), .en_fts(drop_fts_en),
        .drop(drop_sym)
    );

    assign ei_entry  = elec_idle && (ph != PH_IDLE);
    assign idle_end  = (ph == PH_IDLE) && !elec_idle;
    assign train_end = (ph == PH_TRAIN) && (elec_idle || !fts_part);

    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_RUN:   if (elec_idle) ph_nxt = PH_IDLE;
            PH_IDLE:  if (!elec_idle) ph_nxt = PH_TRAIN;
            PH_TRAIN: begin
                if (elec_idle)      ph_nxt = PH_IDLE;
                else if (!fts_part) ph_nxt = PH_RUN;
            end
            default:  ph_nxt = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_RUN;
        else        ph <= ph_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eios_det        <= 1'b0;
            fts_det         <= 1'b0;
            trig_pulse      <= 1'b0;
            idle_len_valid  <= 1'b0;
            idle_len        <= '0;
            idle_after_eios <= 1'b0;
            fts_cnt_valid   <= 1'b0;
            fts_cnt         <= '0;
            eios_flag       <= 1'b0;
        end else begin
            eios_det       <= eios_hit;
            fts_det        <= fts_hit;
            trig_pulse     <= ei_entry && trig_en && (trig_side == link_side);
            idle_len_valid <= idle_end;
            fts_cnt_valid  <= train_end;
            if (idle_end) begin
                idle_len        <= idle_q;
                idle_after_eios <= eios_flag;
            end
            if (train_end) fts_cnt <= fts_q;
            if (eios_hit)        eios_flag <= 1'b1;
            else if (!elec_idle) eios_flag <= 1'b0;
        end
    end

    AST_TRIG_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(elec_idle)); // R4
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse); // R4
    AST_IDLE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        idle_len_valid |-> (!$past(elec_idle) && (idle_len != '0))); // R5
    AST_REPORTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_len_valid && fts_cnt_valid)); // R8
endmodule

// File: tb/lowpower_os_monitor_tb.sv
module lowpower_os_monitor_tb;
    localparam int IW = 16;
    localparam int FW = 13;
    localparam logic [7:0] COM = 8'hBC, IDL = 8'h7C, FTS = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] sym_data = '0;
    logic sym_is_k = 1'b0, elec_idle = 1'b0, link_side = 1'b0;
    logic trig_en = 1'b1, trig_side = 1'b0, drop_idle_en = 1'b0, drop_fts_en = 1'b0;
    logic eios_det, fts_det, trig_pulse, idle_len_valid, idle_after_eios;
    logic fts_cnt_valid, drop_sym;
    logic [IW-1:0] idle_len;
    logic [FW-1:0] fts_cnt;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    lowpower_os_monitor #(.IDLE_W(IW), .FTS_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sym_data(sym_data), .sym_is_k(sym_is_k),
        .elec_idle(elec_idle), .link_side(link_side), .trig_en(trig_en),
        .trig_side(trig_side), .drop_idle_en(drop_idle_en), .drop_fts_en(drop_fts_en),
        .eios_det(eios_det), .fts_det(fts_det), .trig_pulse(trig_pulse),
        .idle_len_valid(idle_len_valid), .idle_len(idle_len),
        .idle_after_eios(idle_after_eios), .fts_cnt_valid(fts_cnt_valid),
        .fts_cnt(fts_cnt), .drop_sym(drop_sym)
    );

    always #10 clk = ~clk;

    // reference state
    logic [7:0] hd [1:3];
    logic       hk [1:3];
    logic       he [1:3];
    int         m_ph = 0;
    logic [IW-1:0] m_icnt = '0;
    logic [FW-1:0] m_fcnt = '0;
    logic m_eflag = 1'b0;
    logic [3:0] m_span = '0, m_gap = '0;

    function automatic bit is_sym(input logic [7:0] d, input logic k,
                                  input logic e, input logic [7:0] code);
        return !e && k && (d == code);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] d, input logic k, input logic e);
        bit hitE, hitF, fpart, entry, x_trig, x_ilv, x_fv, x_drop;
        logic [IW-1:0] x_il;
        logic [FW-1:0] x_fc;
        logic x_pref;
        sym_data = d; sym_is_k = k; elec_idle = e;
        hitE = is_sym(d,k,e,IDL) && is_sym(hd[1],hk[1],he[1],IDL) &&
               is_sym(hd[2],hk[2],he[2],IDL) && is_sym(hd[3],hk[3],he[3],COM);
        hitF = is_sym(d,k,e,FTS) && is_sym(hd[1],hk[1],he[1],FTS) &&
               is_sym(hd[2],hk[2],he[2],FTS) && is_sym(hd[3],hk[3],he[3],COM);
        fpart = is_sym(d,k,e,COM) || (is_sym(d,k,e,FTS) &&
                (is_sym(hd[1],hk[1],he[1],COM) ||
                 (is_sym(hd[1],hk[1],he[1],FTS) && is_sym(hd[2],hk[2],he[2],COM)) ||
                 (is_sym(hd[1],hk[1],he[1],FTS) && is_sym(hd[2],hk[2],he[2],FTS) &&
                  is_sym(hd[3],hk[3],he[3],COM))));
        entry  = e && (m_ph != 1);
        x_trig = entry && trig_en && (trig_side == link_side);
        x_ilv  = (m_ph == 1) && !e;
        x_il   = m_icnt;
        x_pref = m_eflag;
        x_fv   = (m_ph == 2) && (e || !fpart);
        x_fc   = m_fcnt;
        m_span = {m_span[2:0], 1'b0} |
                 (((hitE && drop_idle_en) || (hitF && drop_fts_en)) ? 4'hF : 4'h0);
        m_gap  = {m_gap[2:0], e && drop_idle_en};
        x_drop = m_span[3] | m_gap[3];
        if (hitE) m_eflag = 1'b1; else if (!e) m_eflag = 1'b0;
        if (entry) m_icnt = 1;
        else if (m_ph == 1 && e && m_icnt != '1) m_icnt = m_icnt + 1'b1;
        if (m_ph == 1 && !e) m_fcnt = '0;
        else if (m_ph == 2 && hitF && m_fcnt != '1) m_fcnt = m_fcnt + 1'b1;
        if (m_ph == 0) begin if (e) m_ph = 1; end
        else if (m_ph == 1) begin if (!e) m_ph = 2; end
        else begin if (e) m_ph = 1; else if (!fpart) m_ph = 0; end
        hd[3] = hd[2]; hk[3] = hk[2]; he[3] = he[2];
        hd[2] = hd[1]; hk[2] = hk[1]; he[2] = he[1];
        hd[1] = d;     hk[1] = k;     he[1] = e;
        @(posedge clk);
        @(negedge clk);
        chk("R1 eios_det", eios_det, hitE);
        chk("R2/R3 fts_det", fts_det, hitF);
        chk("R4 trig_pulse", trig_pulse, x_trig);
        chk("R5 idle_len_valid", idle_len_valid, x_ilv);
        if (x_ilv) begin
            chk("R5/R6 idle_len", idle_len, x_il);
            chk("R7 idle_after_eios", idle_after_eios, x_pref);
        end
        chk("R8 fts_cnt_valid", fts_cnt_valid, x_fv);
        if (x_fv) chk("R8 fts_cnt", fts_cnt, x_fc);
        chk("R9 drop_sym", drop_sym, x_drop);
    endtask

    task automatic send_set(input logic [7:0] s);
        step(COM, 1'b1, 1'b0); step(s, 1'b1, 1'b0);
        step(s, 1'b1, 1'b0);   step(s, 1'b1, 1'b0);
    endtask

    task automatic idle_for(input int n);
        for (int i = 0; i < n; i++) step(8'h00, 1'b0, 1'b1);
    endtask

    task automatic data_sym();
        step(8'($urandom), 1'b0, 1'b0);
    endtask

    initial begin
        for (int i = 1; i <= 3; i++) begin hd[i] = '0; hk[i] = 1'b0; he[i] = 1'b1; end
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset eios_det", eios_det, 0);
        chk("R10 reset trig", trig_pulse, 0);
        chk("R10 reset valids", {idle_len_valid, fts_cnt_valid}, 0);
        chk("R10 reset drop", drop_sym, 0);
        rst_n = 1'b1;
        // directed: full episode, R1 R4 R5 R7 R8
        data_sym(); data_sym();
        send_set(IDL);
        idle_for(5);
        send_set(FTS); send_set(FTS); send_set(FTS);
        data_sym(); data_sym();
        // R3: broken sets and restart
        step(COM,1,0); step(IDL,1,0); step(IDL,0,0); step(IDL,1,0);
        step(COM,1,0); step(FTS,1,0); step(COM,1,0); step(FTS,1,0);
        step(FTS,1,0); step(FTS,1,0);
        step(COM,1,0); step(IDL,1,0); idle_for(1); step(IDL,1,0); step(IDL,1,0);
        // coincidence: idle returns mid-training (R4 with R8), filters on (R9)
        drop_idle_en = 1'b1; drop_fts_en = 1'b1;
        send_set(IDL); idle_for(3);
        send_set(FTS); send_set(FTS); idle_for(4);
        send_set(FTS); data_sym();
        // side mismatch: no trigger (R4)
        trig_side = 1'b1; link_side = 1'b0;
        idle_for(2); data_sym(); data_sym();
        trig_side = 1'b0;
        // random episodes
        for (int seg = 0; seg < 600; seg++) begin
            int r;
            r = int'($urandom % 8);
            case (r)
                0: begin
                    send_set(IDL); idle_for(1 + int'($urandom % 40));
                    for (int j = 0; j < int'($urandom % 5); j++) send_set(FTS);
                    data_sym();
                end
                1: for (int j = 0; j < 1 + int'($urandom % 6); j++) data_sym();
                2: begin step(COM,1,0); step(IDL,1,0); data_sym(); end
                3: send_set(FTS);
                4: begin
                    trig_en = 1'($urandom); trig_side = 1'($urandom);
                    link_side = 1'($urandom);
                    drop_idle_en = 1'($urandom); drop_fts_en = 1'($urandom);
                end
                5: idle_for(1 + int'($urandom % 8));
                6: begin step(COM,1,0); step(IDL,1,0); send_set(FTS); end
                default: begin
                    logic [7:0] pick;
                    pick = ($urandom % 3 == 0) ? COM : (($urandom % 2 == 0) ? IDL : FTS);
                    step(pick, 1'($urandom), 1'b0);
                end
            endcase
        end
        // R6: saturation of the idle length
        data_sym();
        idle_for(66000);
        data_sym(); data_sym();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule